// File: doc/BRIEF.md
# TDM master serial port

This block is a multi-slot time-division-multiplexed serial port that acts as master on both directions. It derives a bit clock from the system clock through an integer divider and produces a frame sync. Each frame carries a programmable number of 8-bit slots. Transmit and receive run from the same internal clock and frame timing, so the two directions stay aligned.

Parallel words for transmission come from a show-ahead transmit FIFO. Received words go to a receive FIFO. A per-slot mask selects which slots carry data. Only active slots consume from the transmit FIFO or produce into the receive FIFO. Masked slots send a quiet line and ignore what arrives. The port sets sticky flags when the transmit FIFO runs dry or the receive FIFO refuses a word.

The serial outputs are plain registered signals in the system clock domain. Transmit data changes on falling bit-clock edges. Receive data is captured on rising bit-clock edges.

Top module: `tdm_master_port`

## Requirements
- R1: `bclk` is high during reset. Each of its high and low phases lasts exactly CLK_DIV system clock cycles, so the first falling edge comes CLK_DIV cycles after reset is released.
- R2: A frame holds `slot_cnt_m1`+1 slots of SLOT_BITS bits, and the first falling edge after reset starts bit 0 of slot 0. `fsync` is high during reset and during the last bit of the last slot, which is the bit period just before bit 0 of slot 0. It is low in every other bit period and changes only together with a falling edge of `bclk`.
- R3: `txd` changes only on falling edges of `bclk`. In an active slot, the slot value is the popped word ANDed with a mask of the low `word_len_m1`+1 bits, so the word is LSB-aligned and the upper bits are zero. The slot value is sent MSB first.
- R4: `rxd` is captured at each rising edge of `bclk` in an active slot and assembled MSB first. After the rising edge of the slot's last bit, the assembled value, masked to the low `word_len_m1`+1 bits, appears on `rx_word` with a one-cycle `rx_push`.
- R5: A set bit s of `slot_mask` disables slot s. At the falling edge that starts an active slot, `tx_pop` pulses for one cycle if `tx_empty` is low. `tx_pop` never pulses at any other time.
- R6: In a masked slot `txd` is low. `txd_oe` is high when TX_TRISTATE is 0 and low when it is 1. No receive word is produced for a masked slot.
- R7: If `tx_empty` is high when an active slot starts, the slot sends all zeros, no pop is made, and `underrun` is set. `underrun` stays set until reset.
- R8: If `rx_full` is high when a receive word is due, the word is dropped, `rx_push` stays low, and `overrun` is set. `overrun` stays set until reset.
- R9: During reset `txd` is low, `txd_oe` follows the masked-slot rule, and `tx_pop`, `rx_push`, `underrun` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_cnt_m1 | input | $clog2(NUM_SLOTS) | Slots per frame minus one |
| word_len_m1 | input | $clog2(SLOT_BITS) | Valid word bits minus one |
| slot_mask | input | NUM_SLOTS | Bit s set disables slot s |
| tx_data | input | SLOT_BITS | Head word of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_pop | output | 1 | Consume the head word of the transmit FIFO |
| rx_word | output | SLOT_BITS | Received word |
| rx_push | output | 1 | Write `rx_word` into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync pulse |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for `txd` |
| rxd | input | 1 | Serial receive data |
| underrun | output | 1 | Sticky transmit underrun flag |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bit and slot counters are the state that matters most. If one slips, `fsync` moves away from the last bit period within one frame. The next active slot then sends the wrong bit pattern on `txd`, and `tx_pop` lands on the wrong falling edge. A wrong shift register or word-length mask shows up as a wrong serial bit at the very next rising edge, or as a wrong `rx_word` one cycle after a slot's last bit. A stuck sticky flag is visible at the end of each scenario, and a flag that fails to hold is caught after the FIFO condition goes away.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Edge strobes of the bit clock: high in the cycle before the edge takes effect.
    typedef struct packed {
        logic fall;
        logic rise;
    } bclk_evt_t;

    // Mask with the low n bits set.
    function automatic logic [31:0] low_ones(input int unsigned n);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/tdm_clkgen.sv
module tdm_clkgen #(
    parameter int CLK_DIV = 2
) (
    input  logic                clk,
    input  logic                rst,
    output logic                bclk,
    output tdm_pkg::bclk_evt_t  evt
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          bclk;
    } st_t;

    st_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        evt.fall = wrap & st_q.bclk;
        evt.rise = wrap & ~st_q.bclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.bclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk = st_q.bclk;

endmodule

// File: rtl/tdm_sequencer.sv
module tdm_sequencer #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fall,
    input  logic [$clog2(NUM_SLOTS)-1:0]  slot_cnt_m1,
    input  logic [NUM_SLOTS-1:0]          slot_mask,
    output logic [$clog2(SLOT_BITS)-1:0]  bit_idx,
    output logic                          slot_start,
    output logic                          start_active,
    output logic                          active,
    output logic                          fsync
);
    localparam int SLW = $clog2(NUM_SLOTS);
    localparam int BW  = $clog2(SLOT_BITS);
    localparam logic [BW-1:0]  BIT_LAST  = BW'(SLOT_BITS - 1);
    localparam logic [SLW-1:0] SLOT_LAST = SLW'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [BW-1:0]  bitn;
        logic [SLW-1:0] slot;
        logic           act;
        logic           fs;
    } st_t;

    st_t st_d, st_q;
    logic [BW-1:0]  nbit;
    logic [SLW-1:0] nslot;

    always_comb begin
        st_d  = st_q;
        nbit  = (st_q.bitn == BIT_LAST) ? '0 : st_q.bitn + 1'b1;
        nslot = st_q.slot;
        if (st_q.bitn == BIT_LAST) begin
            nslot = (st_q.slot >= slot_cnt_m1) ? '0 : st_q.slot + 1'b1;
        end
        slot_start   = fall && (nbit == '0);
        start_active = ~slot_mask[nslot];
        if (fall) begin
            st_d.bitn = nbit;
            st_d.slot = nslot;
            st_d.fs   = (nbit == BIT_LAST) && (nslot >= slot_cnt_m1);
            if (nbit == '0) begin
                st_d.act = start_active;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bitn <= BIT_LAST;
            st_q.slot <= SLOT_LAST;
            st_q.act  <= 1'b0;
            st_q.fs   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_idx = st_q.bitn;
    assign active  = st_q.act;
    assign fsync   = st_q.fs;

    // R2: the frame sync only ever covers the last bit of a slot
    assert_fsync_lastbit_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.fs |-> (st_q.bitn == BIT_LAST));

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
    parameter int SLOT_BITS   = 8,
    parameter bit TX_TRISTATE = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fall,
    input  logic                          slot_start,
    input  logic                          start_active,
    input  logic [$clog2(SLOT_BITS)-1:0]  word_len_m1,
    input  logic [SLOT_BITS-1:0]          tx_data,
    input  logic                          tx_empty,
    output logic                          tx_pop,
    output logic                          txd,
    output logic                          txd_oe,
    output logic                          underrun
);
    localparam logic IDLE_OE = ~TX_TRISTATE;

    typedef struct packed {
        logic [SLOT_BITS-1:0] shreg;
        logic                 txd;
        logic                 oe;
        logic                 under;
    } st_t;

    st_t st_d, st_q;
    logic [SLOT_BITS-1:0] wmask;
    logic [SLOT_BITS-1:0] word;

    always_comb begin
        st_d   = st_q;
        wmask  = SLOT_BITS'(tdm_pkg::low_ones(32'(word_len_m1) + 32'd1));
        word   = tx_empty ? '0 : (tx_data & wmask);
        tx_pop = slot_start && start_active && !tx_empty;
        if (slot_start) begin
            if (start_active) begin
                st_d.txd   = word[SLOT_BITS-1];
                st_d.shreg = word << 1;
                st_d.oe    = 1'b1;
                if (tx_empty) begin
                    st_d.under = 1'b1;
                end
            end else begin
                st_d.txd   = 1'b0;
                st_d.shreg = '0;
                st_d.oe    = IDLE_OE;
            end
        end else if (fall) begin
            st_d.txd   = st_q.shreg[SLOT_BITS-1];
            st_d.shreg = st_q.shreg << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.shreg <= '0;
            st_q.txd   <= 1'b0;
            st_q.oe    <= IDLE_OE;
            st_q.under <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd      = st_q.txd;
    assign txd_oe   = st_q.oe;
    assign underrun = st_q.under;

    // R7: once raised, the underrun flag holds until reset
    assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.under |=> st_q.under);

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
    parameter int SLOT_BITS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rise,
    input  logic                          active,
    input  logic [$clog2(SLOT_BITS)-1:0]  bit_idx,
    input  logic [$clog2(SLOT_BITS)-1:0]  word_len_m1,
    input  logic                          rxd,
    input  logic                          rx_full,
    output logic [SLOT_BITS-1:0]          rx_word,
    output logic                          rx_push,
    output logic                          overrun
);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_BITS - 1);

    typedef struct packed {
        logic [SLOT_BITS-1:0] acc;
        logic [SLOT_BITS-1:0] word;
        logic                 push;
        logic                 over;
    } st_t;

    st_t st_d, st_q;
    logic [SLOT_BITS-1:0] wmask;
    logic [SLOT_BITS-1:0] acc_n;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        wmask     = SLOT_BITS'(tdm_pkg::low_ones(32'(word_len_m1) + 32'd1));
        acc_n     = {st_q.acc[SLOT_BITS-2:0], rxd};
        if (rise && active) begin
            st_d.acc = acc_n;
            if (bit_idx == BIT_LAST) begin
                if (rx_full) begin
                    st_d.over = 1'b1;
                end else begin
                    st_d.push = 1'b1;
                    st_d.word = acc_n & wmask;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_word = st_q.word;
    assign rx_push = st_q.push;
    assign overrun = st_q.over;

    // R8: once raised, the overrun flag holds until reset
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.over |=> st_q.over);

    // R8: no word is pushed into a full receive FIFO
    assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.push |-> !$past(rx_full));

endmodule

// File: rtl/tdm_master_port.sv
module tdm_master_port #(
    parameter int NUM_SLOTS   = 32,
    parameter int SLOT_BITS   = 8,
    parameter int CLK_DIV     = 2,
    parameter bit TX_TRISTATE = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NUM_SLOTS)-1:0]  slot_cnt_m1,
    input  logic [$clog2(SLOT_BITS)-1:0]  word_len_m1,
    input  logic [NUM_SLOTS-1:0]          slot_mask,
    input  logic [SLOT_BITS-1:0]          tx_data,
    input  logic                          tx_empty,
    output logic                          tx_pop,
    output logic [SLOT_BITS-1:0]          rx_word,
    output logic                          rx_push,
    input  logic                          rx_full,
    output logic                          bclk,
    output logic                          fsync,
    output logic                          txd,
    output logic                          txd_oe,
    input  logic                          rxd,
    output logic                          underrun,
    output logic                          overrun
);
    localparam int BW = $clog2(SLOT_BITS);

    tdm_pkg::bclk_evt_t evt;
    logic [BW-1:0]      bit_idx;
    logic               slot_start;
    logic               start_active;
    logic               active;

    tdm_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
        .clk  (clk),
        .rst  (rst),
        .bclk (bclk),
        .evt  (evt)
    );

    tdm_sequencer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .fall         (evt.fall),
        .slot_cnt_m1  (slot_cnt_m1),
        .slot_mask    (slot_mask),
        .bit_idx      (bit_idx),
        .slot_start   (slot_start),
        .start_active (start_active),
        .active       (active),
        .fsync        (fsync)
    );

    tdm_tx_lane #(.SLOT_BITS(SLOT_BITS), .TX_TRISTATE(TX_TRISTATE)) tx_i (
        .clk          (clk),
        .rst          (rst),
        .fall         (evt.fall),
        .slot_start   (slot_start),
        .start_active (start_active),
        .word_len_m1  (word_len_m1),
        .tx_data      (tx_data),
        .tx_empty     (tx_empty),
        .tx_pop       (tx_pop),
        .txd          (txd),
        .txd_oe       (txd_oe),
        .underrun     (underrun)
    );

    tdm_rx_lane #(.SLOT_BITS(SLOT_BITS)) rx_i (
        .clk         (clk),
        .rst         (rst),
        .rise        (evt.rise),
        .active      (active),
        .bit_idx     (bit_idx),
        .word_len_m1 (word_len_m1),
        .rxd         (rxd),
        .rx_full     (rx_full),
        .rx_word     (rx_word),
        .rx_push     (rx_push),
        .overrun     (overrun)
    );

    // R3: serial transmit data moves only with a falling bit-clock edge
    assert_txd_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !evt.fall |=> $stable(txd));

    // R2: frame sync changes only together with a falling bit-clock edge
    assert_fsync_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(fsync) |-> $fell(bclk));

    // R5: a pop is always followed by the bit clock falling
    assert_pop_at_fall_R5: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> $fell(bclk));

    // R4: a receive push follows a rising-edge strobe
    assert_push_after_rise_R4: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> $past(evt.rise));

endmodule

// File: tb/tdm_master_port_tb_top.sv
module tdm_master_port_tb_top;
    localparam int DIV = 2;
    localparam int NS  = 32;
    localparam int SB  = 8;

    typedef struct packed {
        logic [4:0]  cnt_m1;
        logic [2:0]  wl_m1;
        logic [31:0] mask;
        logic [7:0]  avail;
        logic [7:0]  seed;
        logic [7:0]  frames;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'd3,  3'd7, 32'hFFFF_FFFC, 8'd40, 8'h11, 8'd3},
        '{5'd31, 3'd7, 32'hFFFF_FFFC, 8'd40, 8'h2B, 8'd1},
        '{5'd3,  3'd4, 32'hFFFF_FFF5, 8'd40, 8'h6E, 8'd2},
        '{5'd7,  3'd7, 32'h0000_0000, 8'd5,  8'h93, 8'd2},
        '{5'd0,  3'd0, 32'h0000_0000, 8'd40, 8'hC4, 8'd4},
        '{5'd2,  3'd7, 32'hFFFF_FFFF, 8'd40, 8'h37, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [4:0]  slot_cnt_m1 = '0;
    logic [2:0]  word_len_m1 = '0;
    logic [31:0] slot_mask = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_empty = 1'b1;
    logic        tx_pop;
    logic [7:0]  rx_word;
    logic        rx_push;
    logic        rx_full = 1'b0;
    logic        bclk, fsync, txd, txd_oe;
    logic        rxd = 1'b0;
    logic        underrun, overrun;

    always #5 clk = ~clk;

    tdm_master_port #(.NUM_SLOTS(NS), .SLOT_BITS(SB), .CLK_DIV(DIV), .TX_TRISTATE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .slot_cnt_m1(slot_cnt_m1), .word_len_m1(word_len_m1),
        .slot_mask(slot_mask), .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_word(rx_word), .rx_push(rx_push), .rx_full(rx_full), .bclk(bclk),
        .fsync(fsync), .txd(txd), .txd_oe(txd_oe), .rxd(rxd),
        .underrun(underrun), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;
    int wd = 0;

    // bench model state
    logic [7:0]  seed, wm, cur_word, rtmp;
    logic [31:0] mask_cfg;
    logic        prev_bclk, pop_prev, pend_pop, cur_act, exp_under, exp_over;
    int avail, frame_bits, pos, fcount, tx_k, tx_idx, half_cnt, rx_wr, rx_rd, slot_n, bit_n;
    logic [7:0]  rx_exp [256];

    function automatic logic [7:0] txw(input logic [7:0] s, input int k);
        return 8'(int'(s) + k * 29) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rxw(input logic [7:0] s, input int f, input int sl);
        return 8'(int'(s) * 7 + f * 19 + sl * 45 + 3) ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_tx();
        tx_data  = txw(seed, tx_idx);
        tx_empty = (tx_idx >= avail);
    endtask

    task automatic model_init();
        prev_bclk = 1'b1; pop_prev = 1'b0; pend_pop = 1'b0; cur_act = 1'b0;
        exp_under = 1'b0; exp_over = 1'b0; cur_word = '0;
        pos = frame_bits - 1; fcount = -1; tx_k = 0; tx_idx = 0; half_cnt = 0;
        rx_wr = 0; rx_rd = 0; slot_n = 0; bit_n = SB - 1;
        drive_tx();
    endtask

    task automatic step();
        logic fell, rose;
        @(negedge clk);
        if (pend_pop) begin
            tx_idx++;
            pend_pop = 1'b0;
        end
        drive_tx();
        half_cnt++;
        fell = prev_bclk && !bclk;
        rose = !prev_bclk && bclk;
        if (fell || rose) begin
            chk("R1 half period", half_cnt, DIV);
            half_cnt = 0;
        end
        if (fell) begin
            pos++;
            if (pos == frame_bits) begin
                pos = 0;
                fcount++;
            end
            slot_n = pos / SB;
            bit_n  = pos % SB;
            if (bit_n == 0) begin
                cur_act = !mask_cfg[slot_n];
                chk("R5 pop at slot start", {31'd0, pop_prev}, {31'd0, cur_act && (tx_k < avail)});
                if (cur_act) begin
                    if (tx_k < avail) cur_word = txw(seed, tx_k) & wm;
                    else begin
                        cur_word  = '0;
                        exp_under = 1'b1;
                    end
                    tx_k++;
                end else begin
                    cur_word = '0;
                end
            end else begin
                chk("R5 no pop mid slot", {31'd0, pop_prev}, 32'd0);
            end
            rtmp = rxw(seed, fcount, slot_n);
            rxd  = rtmp[SB-1-bit_n];
        end else if (pop_prev) begin
            chk("R5 pop without edge", 32'd1, 32'd0);
        end
        if (rose) begin
            chk(cur_act ? "R3 tx bit" : "R6 masked txd", {31'd0, txd},
                {31'd0, cur_act ? cur_word[SB-1-bit_n] : 1'b0});
            chk("R6 txd_oe", {31'd0, txd_oe}, 32'd1);
            chk("R2 fsync", {31'd0, fsync}, {31'd0, pos == frame_bits - 1});
            if (cur_act && bit_n == SB - 1) begin
                if (rx_full) exp_over = 1'b1;
                else begin
                    rx_exp[rx_wr % 256] = rxw(seed, fcount, slot_n) & wm;
                    rx_wr++;
                end
            end
        end
        if (rx_push) begin
            if (rx_rd < rx_wr) chk("R4 rx word", {24'd0, rx_word}, {24'd0, rx_exp[rx_rd % 256]});
            else chk("R6 unexpected push", 32'd1, 32'd0);
            rx_rd++;
        end
        pop_prev = tx_pop;
        if (tx_pop) pend_pop = 1'b1;
        prev_bclk = bclk;
    endtask

    task automatic run(input vec_t v, input logic full, input logic do_reset);
        slot_cnt_m1 = v.cnt_m1;
        word_len_m1 = v.wl_m1;
        slot_mask   = v.mask;
        rx_full     = full;
        mask_cfg    = v.mask;
        seed        = v.seed;
        avail       = int'(v.avail);
        frame_bits  = (int'(v.cnt_m1) + 1) * SB;
        wm          = 8'((16'd1 << (int'(v.wl_m1) + 1)) - 16'd1);
        if (do_reset) begin
            rst = 1'b1;
            model_init();
            repeat (3) @(negedge clk);
            // R9: reset values at the ports
            chk("R1 bclk reset", {31'd0, bclk}, 32'd1);
            chk("R2 fsync reset", {31'd0, fsync}, 32'd1);
            chk("R9 txd reset", {31'd0, txd}, 32'd0);
            chk("R9 txd_oe reset", {31'd0, txd_oe}, 32'd1);
            chk("R9 tx_pop reset", {31'd0, tx_pop}, 32'd0);
            chk("R9 rx_push reset", {31'd0, rx_push}, 32'd0);
            chk("R9 flags reset", {30'd0, underrun, overrun}, 32'd0);
            rst = 1'b0;
        end
        repeat (int'(v.frames) * frame_bits * 2 * DIV + 2) step();
    endtask

    initial begin
        vec_t ov;
        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 1'b0, 1'b1);
            chk("R4 all words pushed", rx_rd, rx_wr);
            chk("R7 underrun flag", {31'd0, underrun}, {31'd0, exp_under});
            chk("R8 overrun flag", {31'd0, overrun}, 32'd0);
        end
        // R8: receive FIFO full in every active slot
        ov = '{5'd1, 3'd7, 32'h0000_0000, 8'd100, 8'h5A, 8'd2};
        run(ov, 1'b1, 1'b1);
        chk("R8 no push when full", rx_wr + rx_rd, 0);
        chk("R8 overrun set", {31'd0, overrun}, 32'd1);
        chk("R7 no underrun", {31'd0, underrun}, 32'd0);
        // R8: flag holds after the FIFO drains, pushes resume
        ov.frames = 8'd1;
        run(ov, 1'b0, 1'b0);
        chk("R8 overrun sticky", {31'd0, overrun}, 32'd1);
        chk("R4 pushes resume", {31'd0, rx_wr > 0}, 32'd1);
        chk("R4 resume count", rx_rd, rx_wr);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", wd);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule